// File: doc/BRIEF.md
# Narrowing High-Half Vector Add/Subtract Unit

This block is a vector datapath stage. It treats two 128-bit operands as packed wide elements and adds or subtracts them element by element. It can round each wide result. It then keeps only the upper half of every wide result. The narrowed halves form a 64-bit vector, which is merged into one half of a 128-bit destination. A qualifier bit picks which half. When the low half is written, the upper half is cleared. When the upper half is written, the old low half is kept.

The element-size code picks one of three wide widths: 16, 32 or 64 bits. The fourth code is reserved. A reserved code raises an illegal flag and returns the old destination unchanged.

The result is registered. It appears one cycle after an input strobe, together with an output-valid pulse.

Top module: `vnarrow_hadd`

## Requirements
- R1: With `op_sub`=0 and `round_en`=0, each narrowed element i equals the upper half of (a_i + b_i) taken modulo 2^W, where W is the wide element width.
- R2: With `op_sub`=1 and `round_en`=0, each narrowed element i equals the upper half of (a_i - b_i) taken modulo 2^W.
- R3: With `round_en`=1, the constant 2^(W/2-1) is added to each wide sum or difference before the upper half is taken. The addition wraps modulo 2^W.
- R4: The size code sets W as follows: 0 gives W=16, 1 gives W=32 and 2 gives W=64. Wide element i sits at bits [i*W +: W] of each operand. Narrowed element i lands at bits [i*W/2 +: W/2] of the 64-bit narrowed vector. Operand bits [63:0] therefore yield narrowed bits [31:0], and operand bits [127:64] yield narrowed bits [63:32].
- R5: Size code 3 sets `illegal` to 1 and makes `dst_new` equal to `dst_old`. Any legal size code sets `illegal` to 0.
- R6: With `upper_sel`=0, `dst_new[63:0]` holds the narrowed vector and `dst_new[127:64]` is zero.
- R7: With `upper_sel`=1, `dst_new[127:64]` holds the narrowed vector and `dst_new[63:0]` equals `dst_old[63:0]`.
- R8: No carry or borrow crosses from one wide element into its neighbour.
- R9: The values `out_valid`, `dst_new` and `illegal` are updated at the clock edge that samples `in_valid`=1. The next cycle without a strobe drops `out_valid` to 0, and `dst_new` and `illegal` hold their values.
- R10: A synchronous active-high `rst` sets `out_valid`, `illegal` and `dst_new` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| op_a | input | 128 | First operand vector |
| op_b | input | 128 | Second operand vector (subtrahend) |
| dst_old | input | 128 | Current destination value |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| round_en | input | 1 | Add rounding constant before narrowing |
| size_code | input | 2 | Wide element size: 0=16, 1=32, 2=64, 3=illegal |
| upper_sel | input | 1 | Write the narrowed vector to the upper destination half |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| dst_new | output | 128 | New destination value |
| illegal | output | 1 | Reserved size code seen |

## Verification
A lane that computes the wrong value shows up in `dst_new` on the cycle after the strobe. The error is confined to the bit field of that narrowed element. A wrongly placed rounding constant or a carry leaking between lanes appears at once in the sweep patterns, including the all-ones lanes where rounding wraps. A merge error shows up in the same cycle as a non-zero upper half, or as a clobbered low half. A fault in the output register shows up as a missing valid pulse, or as a `dst_new` that drifts while no strobe arrives.

// File: rtl/vnarrow_pkg.sv
package vnarrow_pkg;
    parameter int VEC_W      = 128;
    parameter int GROUP_W    = 64;
    parameter int NUM_GROUPS = VEC_W / GROUP_W;
    parameter int NARROW_W   = VEC_W / 2;
    parameter int GROUP_NW   = GROUP_W / 2;
    parameter int MIN_WIDE   = 16;
    parameter int NUM_SIZES  = 3;

    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic [VEC_W-1:0] dst;
    } out_state_t;
endpackage

// File: rtl/vnarrow_lane.sv
module vnarrow_lane #(
    parameter int WIDE_W = 16
) (
    input  logic [WIDE_W-1:0]   a_i,
    input  logic [WIDE_W-1:0]   b_i,
    input  logic                sub_i,
    input  logic                rnd_i,
    output logic [WIDE_W/2-1:0] hi_o
);
    localparam int HALF_W = WIDE_W / 2;
    localparam logic [WIDE_W-1:0] RND_K = {{(WIDE_W-1){1'b0}}, 1'b1} << (HALF_W - 1);

    logic [WIDE_W-1:0] raw;
    logic [WIDE_W-1:0] rounded;

    always_comb begin
        raw     = sub_i ? (a_i - b_i) : (a_i + b_i);
        rounded = raw + (rnd_i ? RND_K : '0);
        hi_o    = rounded[WIDE_W-1:HALF_W];
    end
endmodule

// File: rtl/vnarrow_group.sv
module vnarrow_group
    import vnarrow_pkg::*;
(
    input  logic [GROUP_W-1:0]  a_i,
    input  logic [GROUP_W-1:0]  b_i,
    input  logic                sub_i,
    input  logic                rnd_i,
    input  logic [1:0]          size_i,
    output logic [GROUP_NW-1:0] narrow_o
);
    logic [NUM_SIZES-1:0][GROUP_NW-1:0] cand;

    for (genvar sz = 0; sz < NUM_SIZES; sz++) begin : g_size
        localparam int W     = MIN_WIDE << sz;
        localparam int HW    = W / 2;
        localparam int LANES = GROUP_W / W;
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            vnarrow_lane #(.WIDE_W(W)) u_lane (
                .a_i   (a_i[ln*W +: W]),
                .b_i   (b_i[ln*W +: W]),
                .sub_i (sub_i),
                .rnd_i (rnd_i),
                .hi_o  (cand[sz][ln*HW +: HW])
            );
        end
    end

    always_comb begin
        narrow_o = '0;
        for (int s = 0; s < NUM_SIZES; s++) begin
            if (size_i == 2'(s)) narrow_o = cand[s];
        end
    end
endmodule

// File: rtl/vnarrow_merge.sv
module vnarrow_merge
    import vnarrow_pkg::*;
(
    input  logic [NARROW_W-1:0] narrow_i,
    input  logic [VEC_W-1:0]    dst_old_i,
    input  logic                upper_i,
    input  logic                illegal_i,
    output logic [VEC_W-1:0]    dst_o
);
    localparam int KEEP_W = VEC_W - NARROW_W;

    always_comb begin
        if (illegal_i) begin
            dst_o = dst_old_i;
        end else if (upper_i) begin
            dst_o = {narrow_i, dst_old_i[KEEP_W-1:0]};
        end else begin
            dst_o = {{KEEP_W{1'b0}}, narrow_i};
        end
    end
endmodule

// File: rtl/vnarrow_hadd.sv
module vnarrow_hadd
    import vnarrow_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] op_a,
    input  logic [VEC_W-1:0] op_b,
    input  logic [VEC_W-1:0] dst_old,
    input  logic             op_sub,
    input  logic             round_en,
    input  logic [1:0]       size_code,
    input  logic             upper_sel,
    output logic             out_valid,
    output logic [VEC_W-1:0] dst_new,
    output logic             illegal
);
    logic [NARROW_W-1:0] narrowed;
    logic [VEC_W-1:0]    merged;
    logic                bad_size;
    out_state_t          st_d, st_q;

    assign bad_size = (int'(size_code) >= NUM_SIZES);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        vnarrow_group u_grp (
            .a_i      (op_a[g*GROUP_W +: GROUP_W]),
            .b_i      (op_b[g*GROUP_W +: GROUP_W]),
            .sub_i    (op_sub),
            .rnd_i    (round_en),
            .size_i   (size_code),
            .narrow_o (narrowed[g*GROUP_NW +: GROUP_NW])
        );
    end

    vnarrow_merge u_merge (
        .narrow_i  (narrowed),
        .dst_old_i (dst_old),
        .upper_i   (upper_sel),
        .illegal_i (bad_size),
        .dst_o     (merged)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.illegal = bad_size;
            st_d.dst     = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign dst_new   = st_q.dst;
    assign illegal   = st_q.illegal;
endmodule

// File: rtl/vnarrow_chk.sv
module vnarrow_chk
    import vnarrow_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [VEC_W-1:0] dst_old,
    input logic [1:0]       size_code,
    input logic             upper_sel,
    input logic             out_valid,
    input logic [VEC_W-1:0] dst_new,
    input logic             illegal
);
    localparam int KEEP_W = VEC_W - NARROW_W;

    // R9
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(dst_new) && $stable(illegal)));

    // R5
    bad_size_keeps_dst_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code == 2'd3) |=> (illegal && dst_new == $past(dst_old)));

    // R5
    good_size_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code != 2'd3) |=> !illegal);

    // R6
    low_mode_clears_top_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code != 2'd3 && !upper_sel) |=> (dst_new[VEC_W-1:NARROW_W] == '0));

    // R7
    high_mode_keeps_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code != 2'd3 && upper_sel)
            |=> (dst_new[KEEP_W-1:0] == $past(dst_old[KEEP_W-1:0])));
endmodule

bind vnarrow_hadd vnarrow_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .dst_old   (dst_old),
    .size_code (size_code),
    .upper_sel (upper_sel),
    .out_valid (out_valid),
    .dst_new   (dst_new),
    .illegal   (illegal)
);

// File: tb/vnarrow_hadd_bench.sv
module vnarrow_hadd_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] op_a = '0, op_b = '0, dst_old = '0;
    logic         op_sub = 1'b0, round_en = 1'b0, upper_sel = 1'b0;
    logic [1:0]   size_code = 2'd0;
    logic         out_valid, illegal;
    logic [127:0] dst_new;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    vnarrow_hadd u_vnarrow_hadd (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .dst_old(dst_old), .op_sub(op_sub), .round_en(round_en),
        .size_code(size_code), .upper_sel(upper_sel), .out_valid(out_valid),
        .dst_new(dst_new), .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_narrow(input logic [127:0] a, input logic [127:0] b,
                                               input logic sub, input logic rnd, input int sz);
        logic [63:0] res = '0;
        int w = 16 << sz;
        logic [63:0] mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        for (int g = 0; g < 2; g++) begin
            for (int i = 0; i < 64 / w; i++) begin
                logic [63:0] aw = 64'(a >> (g*64 + i*w)) & mask;
                logic [63:0] bw = 64'(b >> (g*64 + i*w)) & mask;
                logic [63:0] s  = sub ? (aw - bw) : (aw + bw);
                if (rnd) s = s + (64'd1 << (w/2 - 1));
                s = (s & mask) >> (w/2);
                res = res | (s << (g*32 + i*(w/2)));
            end
        end
        return res;
    endfunction

    task automatic apply(input logic [127:0] a, input logic [127:0] b, input logic [127:0] old,
                         input logic sub, input logic rnd, input logic [1:0] sz, input logic up);
        @(negedge clk);
        op_a = a; op_b = b; dst_old = old; op_sub = sub; round_en = rnd;
        size_code = sz; upper_sel = up; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 valid", 128'(out_valid), 128'd0);
        chk("R10 dst", dst_new, 128'd0);
        chk("R10 illegal", 128'(illegal), 128'd0);
        rst = 1'b0;

        // Sweep every size, operation, rounding and half-select combination
        for (int sz = 0; sz < 4; sz++)
        for (int sb = 0; sb < 2; sb++)
        for (int rd = 0; rd < 2; rd++)
        for (int up = 0; up < 2; up++)
        for (int p = 0; p < 8; p++) begin
            logic [127:0] a, b, old, exp;
            logic [63:0]  nr;
            string tag;
            old = rnd128();
            case (p)
                0: begin a = '1; b = '0; end          // rounding wraps
                1: begin a = '0; b = {8{16'h0001}}; end
                2: begin a = {8{16'h7F80}}; b = {8{16'h0080}}; end
                3: begin a = '1; b = '1; end
                default: begin a = rnd128(); b = rnd128(); end
            endcase
            apply(a, b, old, sb[0], rd[0], 2'(sz), up[0]);
            chk("R9 valid", 128'(out_valid), 128'd1);
            if (sz == 3) begin
                chk("R5 dst kept", dst_new, old);
                chk("R5 flag", 128'(illegal), 128'd1);
            end else begin
                nr  = ref_narrow(a, b, sb[0], rd[0], sz);
                tag = rd ? "R3 round" : (sb ? "R2 sub" : "R1 add");
                chk("R5 flag clear", 128'(illegal), 128'd0);
                if (up) begin
                    chk(tag, 128'(dst_new[127:64]), 128'(nr));
                    chk("R7 low kept", 128'(dst_new[63:0]), 128'(old[63:0]));
                end else begin
                    chk(tag, 128'(dst_new[63:0]), 128'(nr));
                    chk("R6 top zero", 128'(dst_new[127:64]), 128'd0);
                end
            end
        end

        // R4 element placement, 32-bit wide lanes
        apply(128'h0004_0000_0003_0000_0002_0000_0001_0000, '0, '1, 1'b0, 1'b0, 2'd1, 1'b0);
        chk("R4 order", dst_new, 128'h0000_0000_0000_0000_0004_0003_0002_0001);
        // R4 64-bit wide lanes
        apply(128'h0000_0022_0000_0000_0000_0011_0000_0000, '0, '0, 1'b0, 1'b0, 2'd2, 1'b0);
        chk("R4 group", dst_new, 128'h0000_0000_0000_0000_0000_0022_0000_0011);

        // R8 no carry between lanes
        apply({8{16'hFFFF}}, {8{16'h0001}}, '0, 1'b0, 1'b0, 2'd0, 1'b0);
        chk("R8 carry", dst_new, 128'd0);
        apply({4{32'h0000_0000}}, {4{32'h0000_0001}}, '0, 1'b1, 1'b0, 2'd1, 1'b0);
        chk("R8 borrow", dst_new, 128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF);

        // R9 hold while idle
        apply({8{16'h1234}}, '0, '0, 1'b0, 1'b0, 2'd0, 1'b0);
        op_a = '1; size_code = 2'd3;
        @(negedge clk);
        chk("R9 valid drop", 128'(out_valid), 128'd0);
        chk("R9 dst hold", dst_new, 128'h0000_0000_0000_0000_1212_1212_1212_1212);
        chk("R9 flag hold", 128'(illegal), 128'd0);

        // R10 reset after activity
        apply('1, '0, '1, 1'b0, 1'b0, 2'd3, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 dst", dst_new, 128'd0);
        chk("R10 illegal", 128'(illegal), 128'd0);
        chk("R10 valid", 128'(out_valid), 128'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule